// File: doc/BRIEF.md
# Bulk OUT Endpoint Receive-to-Memory Mover

This block empties a device endpoint's receive FIFO into system memory while the processor does other work. Software writes a start address and a buffer length, then sets the endpoint and channel enables. From then on, every packet that arrives with exactly the endpoint's maximum packet size is copied over a simple bus-master write port. The block then retires the packet by pulsing the endpoint's packet-ready clear.

The run ends in one of two ways. A packet shorter than the maximum size, including one of zero length, stays in the FIFO untouched. The block raises a short-packet interrupt so that software can read the byte count and unload the packet itself. If the buffer fills up, the block stops instead. This happens when the remaining length runs out partway through a packet, or is already zero when a full packet arrives. The block then raises a separate overflow interrupt.

The write address register moves forward as data is written. Software finds the number of bytes moved by subtracting the start address from it. Each bus beat carries one data word, and every count in this block is in words. With the default 8-bit width, one word is one byte.

Top module: `usbOutDma`

## Requirements
- R1: After reset, `busReq`, `memWr`, `fifoRdEn`, `pktRdyClr`, `shortSt`, `ovfSt` and `irq` are 0, and `curAddr` and `remCount` are 0.
- R2: A packet is acted on only while all six enables are set: `epCfg[0]` auto-clear, `epCfg[1]` endpoint DMA enable, `epCfg[2]` endpoint DMA mode, `chCfg[0]` channel enable, `chCfg[1]` channel mode and `chCfg[2]` channel interrupt enable. With any one of them clear, a ready packet causes no request, no FIFO read, no status and no address change.
- R3: A ready packet with `rxCount` not below `epMaxPkt` (and `epMaxPkt` nonzero) raises `busReq`, which stays high until granted. Exactly `epMaxPkt` words are written, one for each cycle with `busGnt` high, in FIFO order, to consecutive addresses starting at `curAddr`.
- R4: In the cycle after the last word of a full packet, `pktRdyClr` is high for exactly one cycle and `busReq` is low. This drops the request between packets.
- R5: A ready packet with `rxCount` below `epMaxPkt` causes no request and no FIFO read. It leaves `pktRdy` set and sets `shortSt`.
- R6: Each written word adds one to `curAddr` and subtracts one from `remCount`. After a run, `curAddr` minus the start address equals the number of words written.
- R7: If `remCount` reaches zero while words of the packet remain, or is zero when a full packet is ready, `ovfSt` is set. The rest of the packet stays in the FIFO, `pktRdyClr` is not pulsed, and writing stops. A packet that exactly fills the remaining length completes normally.
- R8: `shortSt` and `ovfSt` stay set until a 1 is written to `intClr[0]` or `intClr[1]` respectively. While either is set, no new packet is started.
- R9: `irq` is high when `shortSt` or `ovfSt` is set and `chCfg[2]` is 1, and low otherwise.
- R10: An `epMaxPkt` of zero makes every ready packet a short packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epCfg | input | 3 | Endpoint bits: [0] auto-clear, [1] DMA enable, [2] DMA mode |
| epMaxPkt | input | 7 | Endpoint maximum packet size in words |
| chCfg | input | 3 | Channel bits: [0] enable, [1] mode, [2] interrupt enable |
| pktRdy | input | 1 | Endpoint holds a received packet |
| rxCount | input | 7 | Word count of the held packet |
| pktRdyClr | output | 1 | One-cycle pulse that retires the held packet |
| fifoRdEn | output | 1 | Pops the FIFO head (head word shown on fifoData) |
| fifoData | input | DATA_W | FIFO head word |
| busReq | output | 1 | Bus mastership request |
| busGnt | input | 1 | Bus grant; a write happens in each cycle with both high |
| memWr | output | 1 | Memory write strobe |
| memWrData | output | DATA_W | Word being written |
| swAddrWr | input | 1 | Load strobe for the address register |
| swAddrData | input | ADDR_W | Start address to load |
| swCountWr | input | 1 | Load strobe for the remaining-length register |
| swCountData | input | CNT_W | Buffer length in words to load |
| intClr | input | 2 | Write-1-to-clear: [0] short status, [1] overflow status |
| curAddr | output | ADDR_W | Current address, also the write address |
| remCount | output | CNT_W | Words of buffer space left |
| shortSt | output | 1 | Sticky short-packet status |
| ovfSt | output | 1 | Sticky buffer-overflow status |
| irq | output | 1 | Interrupt line |

## Verification
The sweep covers every maximum size from one to four, zero to three full packets, and every short-packet length. Buffer lengths are set to an exact fit, one word short, and a few words spare. An off-by-one in the length test would let a write land past the buffer, or would flag overflow on a buffer that fits exactly. The bench also checks the case where the buffer runs out mid-packet. A design that cleared the packet there, or pulled the remainder out of the FIFO, would lose data, and the count of clear pulses and the FIFO read position catch both. Further checks cover each single missing enable, a zero maximum size, and a packet offered while status is still pending. A design that ignored these gates would start bus traffic that software never asked for.

// File: rtl/usbOutDmaPkg.sv
package usbOutDmaPkg;

  localparam int MPS_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } dmaStateT;

  typedef struct packed {
    logic ldBeats;   // load packet word counter at start
    logic beatStep;  // one word written this cycle
    logic setShort;  // flag short packet
    logic setOvf;    // flag buffer overflow
  } dmaStrobeT;

endpackage

// File: rtl/usbOutDmaCtrl.sv
module usbOutDmaCtrl
  import usbOutDmaPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runOk,
  input  logic             pktRdy,
  input  logic [MPS_W-1:0] rxCount,
  input  logic [MPS_W-1:0] maxPkt,
  input  logic             busGnt,
  input  logic             beatsLast,
  input  logic             remLast,
  input  logic             remZero,
  input  logic             anySt,
  output dmaStrobeT        strb,
  output logic             busReq,
  output logic             fifoRdEn,
  output logic             memWr,
  output logic             pktRdyClr
);

  dmaStateT state, stateNxt;
  logic     shortPkt;
  logic     startOk;

  assign shortPkt = (maxPkt == '0) || (rxCount < maxPkt);
  assign startOk  = runOk && pktRdy && !anySt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt  = state;
    strb      = '0;
    busReq    = 1'b0;
    fifoRdEn  = 1'b0;
    memWr     = 1'b0;
    pktRdyClr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startOk) begin
          if (shortPkt) begin
            strb.setShort = 1'b1;
          end else if (remZero) begin
            strb.setOvf = 1'b1;
          end else begin
            strb.ldBeats = 1'b1;
            stateNxt     = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        busReq = 1'b1;
        if (busGnt) begin
          strb.beatStep = 1'b1;
          fifoRdEn      = 1'b1;
          memWr         = 1'b1;
          if (beatsLast) begin
            stateNxt = ST_DONE;
          end else if (remLast) begin
            strb.setOvf = 1'b1;
            stateNxt    = ST_IDLE;
          end
        end
      end
      ST_DONE: begin
        pktRdyClr = 1'b1;
        stateNxt  = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt |=> busReq);

  // R4
  clr_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktRdyClr |-> !busReq && $past(memWr));

  // R4
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktRdyClr |=> !pktRdyClr);

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(runOk));

  // R5
  short_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setShort |-> !busReq && !fifoRdEn);

  // R8
  hold_while_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(anySt) && $past(state == ST_IDLE) |-> !busReq);

endmodule

// File: rtl/usbOutDmaPath.sv
module usbOutDmaPath
  import usbOutDmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobeT         strb,
  input  logic [MPS_W-1:0]  maxPkt,
  input  logic              swAddrWr,
  input  logic [ADDR_W-1:0] swAddrData,
  input  logic              swCountWr,
  input  logic [CNT_W-1:0]  swCountData,
  input  logic [1:0]        intClr,
  input  logic [DATA_W-1:0] fifoData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  remCount,
  output logic [DATA_W-1:0] memWrData,
  output logic              beatsLast,
  output logic              remLast,
  output logic              remZero,
  output logic              shortSt,
  output logic              ovfSt
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [MPS_W-1:0]  BEAT_ONE = MPS_W'(1);

  logic [MPS_W-1:0] beatsLeft;

  always_ff @(posedge clk) begin
    if (!rstN)              beatsLeft <= '0;
    else if (strb.ldBeats)  beatsLeft <= maxPkt;
    else if (strb.beatStep) beatsLeft <= beatsLeft - BEAT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              curAddr <= '0;
    else if (swAddrWr)      curAddr <= swAddrData;
    else if (strb.beatStep) curAddr <= curAddr + ADDR_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              remCount <= '0;
    else if (swCountWr)     remCount <= swCountData;
    else if (strb.beatStep) remCount <= remCount - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shortSt <= 1'b0;
      ovfSt   <= 1'b0;
    end else begin
      shortSt <= (shortSt & ~intClr[0]) | strb.setShort;
      ovfSt   <= (ovfSt & ~intClr[1]) | strb.setOvf;
    end
  end

  assign beatsLast = (beatsLeft == BEAT_ONE);
  assign remLast   = (remCount == CNT_ONE);
  assign remZero   = (remCount == '0);
  assign memWrData = fifoData;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatStep && !swAddrWr |=> curAddr == $past(curAddr) + ADDR_ONE);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatStep && !swCountWr |=> remCount == $past(remCount) - CNT_ONE);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatStep |-> !remZero);

  // R8
  short_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    shortSt && !intClr[0] |=> shortSt);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfSt && !intClr[1] |=> ovfSt);

endmodule

// File: rtl/usbOutDma.sv
module usbOutDma
  import usbOutDmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        epCfg,
  input  logic [MPS_W-1:0]  epMaxPkt,
  input  logic [2:0]        chCfg,
  input  logic              pktRdy,
  input  logic [MPS_W-1:0]  rxCount,
  output logic              pktRdyClr,
  output logic              fifoRdEn,
  input  logic [DATA_W-1:0] fifoData,
  output logic              busReq,
  input  logic              busGnt,
  output logic              memWr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              swAddrWr,
  input  logic [ADDR_W-1:0] swAddrData,
  input  logic              swCountWr,
  input  logic [CNT_W-1:0]  swCountData,
  input  logic [1:0]        intClr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  remCount,
  output logic              shortSt,
  output logic              ovfSt,
  output logic              irq
);

  dmaStrobeT strb;
  logic      runOk;
  logic      beatsLast, remLast, remZero;

  assign runOk = (&epCfg) && (&chCfg);
  assign irq   = (shortSt | ovfSt) & chCfg[2];

  usbOutDmaCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .runOk     (runOk),
    .pktRdy    (pktRdy),
    .rxCount   (rxCount),
    .maxPkt    (epMaxPkt),
    .busGnt    (busGnt),
    .beatsLast (beatsLast),
    .remLast   (remLast),
    .remZero   (remZero),
    .anySt     (shortSt | ovfSt),
    .strb      (strb),
    .busReq    (busReq),
    .fifoRdEn  (fifoRdEn),
    .memWr     (memWr),
    .pktRdyClr (pktRdyClr)
  );

  usbOutDmaPath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .maxPkt      (epMaxPkt),
    .swAddrWr    (swAddrWr),
    .swAddrData  (swAddrData),
    .swCountWr   (swCountWr),
    .swCountData (swCountData),
    .intClr      (intClr),
    .fifoData    (fifoData),
    .curAddr     (curAddr),
    .remCount    (remCount),
    .memWrData   (memWrData),
    .beatsLast   (beatsLast),
    .remLast     (remLast),
    .remZero     (remZero),
    .shortSt     (shortSt),
    .ovfSt       (ovfSt)
  );

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> chCfg[2] && (shortSt || ovfSt));

endmodule

// File: tb/usbOutDma_test.sv
module usbOutDma_test;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        epCfg = '0;
  logic [6:0]        epMaxPkt = '0;
  logic [2:0]        chCfg = '0;
  logic              pktRdy;
  logic [6:0]        rxCount = '0;
  logic              pktRdyClr, fifoRdEn, busReq, busGnt, memWr;
  logic [DATA_W-1:0] fifoData, memWrData;
  logic              swAddrWr = 1'b0, swCountWr = 1'b0;
  logic [ADDR_W-1:0] swAddrData = '0;
  logic [CNT_W-1:0]  swCountData = '0;
  logic [1:0]        intClr = '0;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remCount;
  logic              shortSt, ovfSt, irq;

  // bench-side models
  logic       pktSet = 1'b0, pktDrop = 1'b0, memFill = 1'b0;
  logic [7:0] pktBuf [128];
  logic [7:0] mem [256];
  int         rdIdx, clrCnt, reqCnt, cycles;
  logic [1:0] gntPh;
  logic       gntSlow = 1'b0;
  int         nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  usbOutDma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .epCfg(epCfg), .epMaxPkt(epMaxPkt), .chCfg(chCfg),
    .pktRdy(pktRdy), .rxCount(rxCount), .pktRdyClr(pktRdyClr),
    .fifoRdEn(fifoRdEn), .fifoData(fifoData), .busReq(busReq), .busGnt(busGnt),
    .memWr(memWr), .memWrData(memWrData), .swAddrWr(swAddrWr),
    .swAddrData(swAddrData), .swCountWr(swCountWr), .swCountData(swCountData),
    .intClr(intClr), .curAddr(curAddr), .remCount(remCount),
    .shortSt(shortSt), .ovfSt(ovfSt), .irq(irq)
  );

  assign fifoData = pktBuf[rdIdx[6:0]];
  assign busGnt   = busReq && (!gntSlow || gntPh != 2'd0);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    gntPh  <= gntPh + 2'd1;
    if (pktRdyClr) clrCnt <= clrCnt + 1;
    if (busReq)    reqCnt <= reqCnt + 1;
    if (pktRdyClr)    pktRdy <= 1'b0;
    else if (pktSet)  pktRdy <= 1'b1;
    else if (pktDrop) pktRdy <= 1'b0;
    if (pktSet)        rdIdx <= 0;
    else if (fifoRdEn) rdIdx <= rdIdx + 1;
    if (memFill) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hEE;
    end else if (memWr) begin
      mem[curAddr[7:0]] <= memWrData;
    end
  end

  initial begin
    pktRdy = 1'b0; rdIdx = 0; clrCnt = 0; reqCnt = 0; cycles = 0; gntPh = '0;
  end

  function automatic logic [7:0] dat(input int g);
    return 8'((g * 2 + 1) & 127);
  endfunction

  task automatic chkEq(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    finishRun();
  end

  task automatic setup(input int mps, input int startA, input int bufLen);
    @(negedge clk);
    epCfg = 3'b111; chCfg = 3'b111; epMaxPkt = 7'(mps);
    intClr = 2'b11; memFill = 1'b1;
    swAddrWr = 1'b1; swAddrData = ADDR_W'(startA);
    swCountWr = 1'b1; swCountData = CNT_W'(bufLen);
    @(negedge clk);
    intClr = 2'b00; memFill = 1'b0; swAddrWr = 1'b0; swCountWr = 1'b0;
  endtask

  task automatic offer(input int len, input int base);
    for (int i = 0; i < 128; i++) pktBuf[i] = (i < len) ? dat(base + i) : 8'h55;
    rxCount = 7'(len);
    pktSet = 1'b1;
    @(negedge clk);
    pktSet = 1'b0;
  endtask

  task automatic dropPkt();
    pktDrop = 1'b1;
    @(negedge clk);
    pktDrop = 1'b0;
    @(negedge clk);
  endtask

  task automatic stream(input int scn, input int mps, input int nFull,
                        input int bufLen, input int shortLen);
    int startA, written, clr0, expClr, w, memBad;
    bit ovfExp;
    startA  = 16 + (scn * 7) % 96;
    ovfExp  = (nFull * mps) > bufLen;
    written = ovfExp ? bufLen : nFull * mps;
    expClr  = ovfExp ? bufLen / mps : nFull;
    setup(mps, startA, bufLen);
    clr0 = clrCnt;
    for (int p = 0; p < nFull; p++) begin
      int prev;
      if (ovfSt) break;
      prev = clrCnt;
      offer(mps, p * mps);
      w = 0;
      while (clrCnt == prev && !ovfSt && w < 300) begin @(negedge clk); w++; end
    end
    if (!ovfExp) begin
      offer(shortLen, 100);
      w = 0;
      while (!shortSt && w < 50) begin @(negedge clk); w++; end
      // R5: short packet left in FIFO, still ready, status raised
      chkEq("R5 short status", shortSt, 1);
      chkEq("R5 short fifo untouched", rdIdx, 0);
      chkEq("R5 short pktRdy kept", pktRdy, 1);
    end else begin
      @(negedge clk);
      // R7: overflow stop, no retire of partial packet
      chkEq("R7 ovf status", ovfSt, 1);
      chkEq("R7 ovf pktRdy kept", pktRdy, 1);
    end
    chkEq("R8 other status clear", ovfExp ? shortSt : ovfSt, 0);
    chkEq("R9 irq", irq, 1);
    // R6: address and remaining length
    chkEq("R6 addr advance", curAddr - ADDR_W'(startA), written);
    chkEq("R6 remaining", remCount, bufLen - written);
    // R4: one retire pulse per completed packet
    chkEq("R4 clear pulses", clrCnt - clr0, expClr);
    // R3: data in FIFO order, nothing past the end
    memBad = 0;
    for (int i = 0; i < written; i++)
      if (mem[8'(startA + i)] != dat(i)) memBad++;
    chkEq("R3 memory contents", memBad, 0);
    chkEq("R7 no write past end", mem[8'(startA + written)], 8'hEE);
    dropPkt();
  endtask

  initial begin
    int scn;
    int r0, a0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chkEq("R1 busReq", busReq, 0);
    chkEq("R1 memWr", memWr, 0);
    chkEq("R1 fifoRdEn", fifoRdEn, 0);
    chkEq("R1 pktRdyClr", pktRdyClr, 0);
    chkEq("R1 status", {shortSt, ovfSt, irq}, 0);
    chkEq("R1 addr", curAddr, 0);
    chkEq("R1 count", remCount, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: each single missing enable blocks operation
    for (int b = 0; b < 6; b++) begin
      setup(2, 40, 20);
      epCfg = (b < 3) ? (3'b111 & ~(3'b1 << b)) : 3'b111;
      chCfg = (b >= 3) ? (3'b111 & ~(3'b1 << (b - 3))) : 3'b111;
      r0 = reqCnt; a0 = curAddr;
      offer(2, 0);
      repeat (15) @(negedge clk);
      chkEq("R2 no request", reqCnt - r0, 0);
      chkEq("R2 no fifo read", rdIdx, 0);
      chkEq("R2 no status", {shortSt, ovfSt}, 0);
      chkEq("R2 addr unchanged", curAddr, a0);
      dropPkt();
    end

    // main sweep: R3 R4 R5 R6 R7 R9
    scn = 0;
    for (int mps = 1; mps <= 4; mps++)
      for (int nFull = 0; nFull <= 3; nFull++)
        for (int bs = 0; bs < 3; bs++) begin
          int bufLen;
          bufLen = nFull * mps + ((bs == 0) ? 0 : (bs == 1) ? -1 : 3);
          if (bufLen < 0) bufLen = 0;
          gntSlow = ((mps + nFull + bs) % 2) == 1;
          stream(scn, mps, nFull, bufLen, (nFull + bs) % mps);
          scn++;
        end

    // R10: zero maximum size -> every packet short
    for (int len = 0; len < 2; len++) begin
      setup(0, 50, 10);
      r0 = reqCnt;
      offer(len * 5, 0);
      repeat (5) @(negedge clk);
      chkEq("R10 zero max short", shortSt, 1);
      chkEq("R10 zero max no request", reqCnt - r0, 0);
      dropPkt();
    end

    // R8: pending status blocks new packet until cleared
    gntSlow = 1'b0;
    setup(3, 60, 30);
    offer(1, 0);
    repeat (4) @(negedge clk);
    r0 = reqCnt;
    offer(3, 0);
    repeat (15) @(negedge clk);
    chkEq("R8 blocked while pending", reqCnt - r0, 0);
    chkEq("R8 status sticky", shortSt, 1);
    // R9: line follows channel interrupt enable
    chCfg = 3'b011;
    @(negedge clk);
    chkEq("R9 irq masked", irq, 0);
    chkEq("R9 status kept", shortSt, 1);
    chCfg = 3'b111;
    r0 = clrCnt;
    intClr = 2'b01;
    @(negedge clk);
    intClr = 2'b00;
    repeat (12) @(negedge clk);
    chkEq("R8 cleared status", shortSt, 0);
    chkEq("R8 resumes after clear", clrCnt - r0, 1);
    chkEq("R8 addr after resume", curAddr, 63);
    dropPkt();

    finishRun();
  end

endmodule